// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one synchronous graphics DRAM from reset until the memory is fit for normal traffic. After reset it holds clock enable and the data mask high and presents only no-operation commands for a stable-power interval. The interval is given in microseconds and converted to cycles from a clock-frequency parameter. It then precharges every bank, issues a parameterized number of auto-refresh commands (never fewer than two), and programs the mode register. A configuration input can place the mode programming ahead of the refreshes.

The mode word is assembled from configuration inputs: burst length, burst ordering, CAS latency, and a flag that makes writes single-beat while reads burst. Before programming, the block checks the combination. A reserved burst-length code, a full-page burst with interleaved ordering, or an unsupported latency stops the sequence and raises a sticky error, and no mode programming is issued. Once ready, the host may request a special mode programming that loads either the mask register or the color register. A request that asks for both is refused with a one-cycle reject pulse.

Top module: `sdram_init_seq`

## Requirements
- R1: From reset until the hold interval of HOLD_US*CLK_MHZ cycles has elapsed, cke and dqm are 1, the command pins {csN,rasN,casN,weN} read 4'b0111 (no-operation), and ready is 0.
- R2: The first non-idle command is a precharge (4'b0010) with addr[10]=1, no sooner than HOLD_US*CLK_MHZ cycles after reset is released.
- R3: The next command follows the precharge exactly T_RP cycles later.
- R4: Exactly NUM_REFRESH auto-refresh commands (4'b0001) are issued, and each is followed by exactly T_RC cycles before the next command or before ready.
- R5: With cfgMrsFirst=0, the order is precharge, all refreshes, then mode programming (4'b0000).
- R6: With cfgMrsFirst=1, the order is precharge, mode programming, then all refreshes.
- R7: The mode programming drives fnSel=0 and an address of addr[2:0]=burst length code, addr[3]=interleave, addr[6:4]=CAS latency, addr[9]=single-write flag, with addr[8:7] and addr[10] at 0. Burst codes: 000=1, 001=2, 010=4, 011=8, 111=full page.
- R8: Burst-length codes 100, 101 and 110 suppress mode programming, set cfgError to 1 and keep it set, and keep ready at 0 with only no-operations afterwards.
- R9: Burst code 111 with cfgInterleave=1 is rejected in the same way as R8.
- R10: A CAS latency other than 3'b010 or 3'b011 is rejected in the same way as R8.
- R11: ready rises exactly T_MRD cycles after a mode programming that ends initialization. While ready is 1, the command pins read no-operation.
- R12: When ready and specReq is set with exactly one of specLoadMask or specLoadColor, the next cycle shows 4'b0000 with fnSel=1, addr[5]=mask and addr[6]=color, and ready=0. ready returns T_MRD cycles later.
- R13: A special request with both load bits set produces one cycle of specReject=1 with no command issued, and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBurstLen | input | 3 | Burst length code |
| cfgInterleave | input | 1 | 1 selects interleaved burst order |
| cfgCasLat | input | 3 | CAS latency code |
| cfgSingleWrite | input | 1 | 1 makes writes single-beat |
| cfgMrsFirst | input | 1 | 1 programs the mode before the refreshes |
| specReq | input | 1 | Request a special mode programming |
| specLoadMask | input | 1 | Special programming loads the mask register |
| specLoadColor | input | 1 | Special programming loads the color register |
| cke | output | 1 | Clock enable pin |
| dqm | output | 1 | Data mask pin, high until ready |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| fnSel | output | 1 | Marks a special mode programming |
| addr | output | ADDR_W | Address pins |
| ready | output | 1 | Initialization complete and idle |
| cfgError | output | 1 | Sticky illegal-configuration flag |
| specReject | output | 1 | One-cycle refusal of a special request |

## Verification
The bench runs each configuration from reset and targets every reserved burst code, the full-page-with-interleave pairing, and bad latencies. A checker that missed any of these would program an undefined mode and raise ready. It measures every command gap and the hold length. An off-by-one wait counter would shift a command by one cycle, and a refresh counter started at the wrong value would issue one refresh too many or too few. Both orderings are exercised, so a design that ignored the order select would show the mode programming at the wrong position. The special path is tested with mask alone, with color alone, and with both. Accepting the both-bits request would issue a command that leaves the registers undefined.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    S_HOLD, S_PRE, S_REF, S_MRS, S_WAIT, S_READY, S_ERR
  } seqState_t;

  typedef struct packed {
    logic doPre;
    logic doRef;
    logic doMrs;
    logic doSpec;
    logic isReady;
    logic isErr;
    logic doReject;
  } initStrobe_t;

endpackage

// File: rtl/sdinit_ctrl.sv
module sdinit_ctrl
  import sdinit_pkg::*;
#(
  parameter int HOLD_CYC    = 20000,
  parameter int NUM_REFRESH = 2,
  parameter int T_RP        = 3,
  parameter int T_RC        = 9,
  parameter int T_MRD       = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgOk,
  input  logic        mrsFirst,
  input  logic        specReq,
  input  logic        specMask,
  input  logic        specColor,
  output initStrobe_t strobe
);

  // waits shorter than two cycles are raised to two; refreshes never below two
  localparam int NREF  = (NUM_REFRESH < 2) ? 2 : NUM_REFRESH;
  localparam int RP_C  = (T_RP  < 2) ? 2 : T_RP;
  localparam int RC_C  = (T_RC  < 2) ? 2 : T_RC;
  localparam int MRD_C = (T_MRD < 2) ? 2 : T_MRD;
  localparam int HOLD_C = (HOLD_CYC < 1) ? 1 : HOLD_CYC;
  localparam int CNT_W = $clog2(HOLD_C + RP_C + RC_C + MRD_C + 1);
  localparam int REF_W = $clog2(NREF + 1);

  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_C - 1);
  localparam logic [CNT_W-1:0] RP_LOAD   = CNT_W'(RP_C - 2);
  localparam logic [CNT_W-1:0] RC_LOAD   = CNT_W'(RC_C - 2);
  localparam logic [CNT_W-1:0] MRD_LOAD  = CNT_W'(MRD_C - 2);
  localparam logic [REF_W-1:0] REF_LAST  = REF_W'(NREF - 1);
  localparam logic [REF_W-1:0] REF_ALL   = REF_W'(NREF);

  seqState_t        state, nextSt;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refCnt;
  logic             mrsDone;
  logic             specBoth, specAccept;

  assign specBoth   = specMask && specColor;
  assign specAccept = (state == S_READY) && specReq && !specBoth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_HOLD;
      nextSt  <= S_HOLD;
      cnt     <= HOLD_LOAD;
      refCnt  <= '0;
      mrsDone <= 1'b0;
    end else begin
      case (state)
        S_HOLD: begin
          if (cnt == '0) state <= S_PRE;
          else           cnt   <= cnt - 1'b1;
        end
        S_PRE: begin
          cnt    <= RP_LOAD;
          nextSt <= mrsFirst ? S_MRS : S_REF;
          state  <= S_WAIT;
        end
        S_REF: begin
          refCnt <= refCnt + 1'b1;
          cnt    <= RC_LOAD;
          if (refCnt != REF_LAST) nextSt <= S_REF;
          else if (mrsDone)       nextSt <= S_READY;
          else                    nextSt <= S_MRS;
          state  <= S_WAIT;
        end
        S_MRS: begin
          if (!cfgOk) begin
            state <= S_ERR;
          end else begin
            mrsDone <= 1'b1;
            cnt     <= MRD_LOAD;
            nextSt  <= (refCnt == REF_ALL) ? S_READY : S_REF;
            state   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cnt == '0) state <= nextSt;
          else           cnt   <= cnt - 1'b1;
        end
        S_READY: begin
          if (specAccept) begin
            cnt    <= MRD_LOAD;
            nextSt <= S_READY;
            state  <= S_WAIT;
          end
        end
        default: state <= S_ERR;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.doPre    = (state == S_PRE);
    strobe.doRef    = (state == S_REF);
    strobe.doMrs    = (state == S_MRS) && cfgOk;
    strobe.doSpec   = specAccept;
    strobe.isReady  = (state == S_READY) && !specAccept;
    strobe.isErr    = (state == S_ERR);
    strobe.doReject = (state == S_READY) && specReq && specBoth;
  end

endmodule

// File: rtl/sdinit_word.sv
module sdinit_word
  import sdinit_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  initStrobe_t       strobe,
  input  logic [2:0]        burstLen,
  input  logic              interleave,
  input  logic [2:0]        casLat,
  input  logic              singleWrite,
  input  logic              specMask,
  input  logic              specColor,
  output logic              cfgOk,
  output logic              cke,
  output logic              dqm,
  output logic [3:0]        cmdPins,
  output logic              fnSel,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              cfgError,
  output logic              specReject
);

  localparam int BL_LSB   = 0;
  localparam int BT_BIT   = 3;
  localparam int CL_LSB   = 4;
  localparam int SW_BIT   = 9;
  localparam int ALL_BIT  = 10;
  localparam int MASK_BIT = 5;
  localparam int COL_BIT  = 6;

  logic              blLegal, clLegal, pageOrder;
  logic [ADDR_W-1:0] modeWord, specWord, preWord, addrNext;
  logic [3:0]        cmdNext;

  always_comb begin
    blLegal   = (burstLen[2] == 1'b0) || (burstLen == 3'b111);
    clLegal   = (casLat == 3'b010) || (casLat == 3'b011);
    pageOrder = !((burstLen == 3'b111) && interleave);
    cfgOk     = blLegal && clLegal && pageOrder;

    modeWord = '0;
    modeWord[BL_LSB +: 3] = burstLen;
    modeWord[BT_BIT]      = interleave;
    modeWord[CL_LSB +: 3] = casLat;
    modeWord[SW_BIT]      = singleWrite;

    specWord = '0;
    specWord[MASK_BIT] = specMask;
    specWord[COL_BIT]  = specColor;

    preWord = '0;
    preWord[ALL_BIT] = 1'b1;

    cmdNext  = CMD_NOP;
    addrNext = '0;
    if (strobe.doPre) begin
      cmdNext  = CMD_PRE;
      addrNext = preWord;
    end else if (strobe.doRef) begin
      cmdNext = CMD_REF;
    end else if (strobe.doMrs) begin
      cmdNext  = CMD_MRS;
      addrNext = modeWord;
    end else if (strobe.doSpec) begin
      cmdNext  = CMD_MRS;
      addrNext = specWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cke        <= 1'b1;
      dqm        <= 1'b1;
      cmdPins    <= CMD_NOP;
      fnSel      <= 1'b0;
      addr       <= '0;
      ready      <= 1'b0;
      cfgError   <= 1'b0;
      specReject <= 1'b0;
    end else begin
      cke        <= 1'b1;
      dqm        <= !strobe.isReady;
      cmdPins    <= cmdNext;
      fnSel      <= strobe.doSpec;
      addr       <= addrNext;
      ready      <= strobe.isReady;
      cfgError   <= strobe.isErr;
      specReject <= strobe.doReject;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int CLK_MHZ     = 100,
  parameter int HOLD_US     = 200,
  parameter int NUM_REFRESH = 2,
  parameter int T_RP        = 3,
  parameter int T_RC        = 9,
  parameter int T_MRD       = 2,
  parameter int ADDR_W      = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgBurstLen,
  input  logic              cfgInterleave,
  input  logic [2:0]        cfgCasLat,
  input  logic              cfgSingleWrite,
  input  logic              cfgMrsFirst,
  input  logic              specReq,
  input  logic              specLoadMask,
  input  logic              specLoadColor,
  output logic              cke,
  output logic              dqm,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              fnSel,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              cfgError,
  output logic              specReject
);

  localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

  initStrobe_t strobe;
  logic        cfgOk;
  logic [3:0]  cmdPins;

  sdinit_ctrl #(
    .HOLD_CYC(HOLD_CYC), .NUM_REFRESH(NUM_REFRESH),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgOk(cfgOk), .mrsFirst(cfgMrsFirst),
    .specReq(specReq), .specMask(specLoadMask), .specColor(specLoadColor),
    .strobe(strobe)
  );

  sdinit_word #(.ADDR_W(ADDR_W)) uWord (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .burstLen(cfgBurstLen), .interleave(cfgInterleave), .casLat(cfgCasLat),
    .singleWrite(cfgSingleWrite), .specMask(specLoadMask), .specColor(specLoadColor),
    .cfgOk(cfgOk), .cke(cke), .dqm(dqm), .cmdPins(cmdPins), .fnSel(fnSel),
    .addr(addr), .ready(ready), .cfgError(cfgError), .specReject(specReject)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

endmodule

// File: rtl/sdinit_chk.sv
module sdinit_chk #(
  parameter int HOLD_CYC = 20000,
  parameter int ADDR_W   = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              dqm,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic              fnSel,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              cfgError,
  input logic              specReject
);

  localparam int SR_W = $clog2(HOLD_CYC + 2) + 1;
  localparam logic [SR_W-1:0] SR_MAX  = {SR_W{1'b1}};
  localparam logic [SR_W-1:0] SR_HOLD = SR_W'(HOLD_CYC);

  logic [SR_W-1:0] sinceRst;
  logic [3:0]      cmd;
  assign cmd = {csN, rasN, casN, weN};

  always_ff @(posedge clk) begin
    if (!rstN)                  sinceRst <= '0;
    else if (sinceRst != SR_MAX) sinceRst <= sinceRst + 1'b1;
  end

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < SR_HOLD) |-> (cke && dqm && cmd == 4'b0111 && !ready));

  a_r2_no_early_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != 4'b0111) |-> (sinceRst >= SR_HOLD));

  a_r2_pre_all_banks: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0010) |-> addr[10]);

  a_r7_mode_rfu_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 4'b0000 && !fnSel) |-> (addr[10] == 1'b0 && addr[8:7] == 2'b00));

  a_r8_error_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (cmd == 4'b0111 && !ready));

  a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> cfgError);

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cmd == 4'b0111));

  a_r12_special_form: assert property (@(posedge clk) disable iff (!rstN)
    fnSel |-> (cmd == 4'b0000 && !(addr[5] && addr[6])));

  a_r13_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    specReject |-> (ready && cmd == 4'b0111 && !fnSel));

endmodule

bind sdram_init_seq sdinit_chk #(.HOLD_CYC(HOLD_CYC), .ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .cke(cke), .dqm(dqm), .csN(csN), .rasN(rasN),
  .casN(casN), .weN(weN), .fnSel(fnSel), .addr(addr), .ready(ready),
  .cfgError(cfgError), .specReject(specReject)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 1;
  localparam int HOLD_US = 200;
  localparam int HOLD    = CLK_MHZ * HOLD_US;
  localparam int NREF    = 3;
  localparam int TRP     = 3;
  localparam int TRC     = 5;
  localparam int TMRD    = 2;
  localparam int NVEC    = 9;

  // {expectOk, mrsFirst, singleWrite, casLat[2:0], interleave, burstLen[2:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1_0_0_010_0_011,
    10'b1_0_1_011_1_000,
    10'b1_1_0_011_0_111,
    10'b1_1_0_010_1_010,
    10'b0_0_0_010_0_100,
    10'b0_1_0_011_0_110,
    10'b0_0_0_011_1_111,
    10'b0_0_0_001_0_001,
    10'b0_1_1_100_0_001
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgBurstLen = 3'b011;
  logic        cfgInterleave = 1'b0;
  logic [2:0]  cfgCasLat = 3'b010;
  logic        cfgSingleWrite = 1'b0;
  logic        cfgMrsFirst = 1'b0;
  logic        specReq = 1'b0;
  logic        specLoadMask = 1'b0;
  logic        specLoadColor = 1'b0;
  logic        cke, dqm, csN, rasN, casN, weN, fnSel, ready, cfgError, specReject;
  logic [10:0] addr;
  logic [3:0]  cmd;

  int checks = 0;
  int errors = 0;

  logic [3:0]  evCmd  [16];
  int          evCyc  [16];
  logic [10:0] evAddr [16];
  logic        evFn   [16];
  int          nEv;
  int          endCyc;
  logic        holdBad;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmd = {csN, rasN, casN, weN};

  sdram_init_seq #(
    .CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD_US), .NUM_REFRESH(NREF),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .ADDR_W(11)
  ) dut (
    .clk(clk), .rstN(rstN), .cfgBurstLen(cfgBurstLen), .cfgInterleave(cfgInterleave),
    .cfgCasLat(cfgCasLat), .cfgSingleWrite(cfgSingleWrite), .cfgMrsFirst(cfgMrsFirst),
    .specReq(specReq), .specLoadMask(specLoadMask), .specLoadColor(specLoadColor),
    .cke(cke), .dqm(dqm), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .fnSel(fnSel), .addr(addr), .ready(ready), .cfgError(cfgError), .specReject(specReject)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runInit(input logic [9:0] v);
    {cfgMrsFirst, cfgSingleWrite, cfgCasLat, cfgInterleave, cfgBurstLen} = v[8:0];
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cke && dqm && cmd == 4'b0111 && !ready && !cfgError, "R1 reset state",
        {cke, dqm, cmd, ready, cfgError}, 8'b11_0111_00);
    rstN = 1'b1;
    nEv = 0;
    holdBad = 1'b0;
    endCyc = 0;
    for (int cyc = 1; cyc <= 2000; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      endCyc = cyc;
      if (nEv == 0 && cmd == 4'b0111 && !(cke && dqm && !ready)) holdBad = 1'b1;
      if (cmd != 4'b0111 && nEv < 16) begin
        evCmd[nEv] = cmd; evCyc[nEv] = cyc; evAddr[nEv] = addr; evFn[nEv] = fnSel;
        nEv++;
      end
      if (ready || cfgError) break;
    end
  endtask

  task automatic checkGood(input logic [9:0] v);
    logic [10:0] expWord;
    int mrsIdx, gap;
    expWord = {1'b0, v[7], 2'b00, v[6:4], v[3], v[2:0]};
    mrsIdx = v[8] ? 1 : NREF + 1;
    chk(!holdBad, "R1 idle during hold", holdBad, 0);
    chk(nEv == NREF + 2, "R4 command count", nEv, NREF + 2);
    if (nEv != NREF + 2) return;
    chk(evCmd[0] == 4'b0010 && evAddr[0][10], "R2 precharge all", evCmd[0], 2);
    chk(evCyc[0] >= HOLD, "R2 hold length", evCyc[0], HOLD);
    chk(evCyc[1] - evCyc[0] == TRP, "R3 precharge gap", evCyc[1] - evCyc[0], TRP);
    for (int i = 1; i < NREF + 2; i++) begin
      if (i == mrsIdx)
        chk(evCmd[i] == 4'b0000, v[8] ? "R6 mode position" : "R5 mode position", evCmd[i], 0);
      else
        chk(evCmd[i] == 4'b0001, v[8] ? "R6 refresh position" : "R5 refresh position", evCmd[i], 1);
      gap = (i == NREF + 1) ? endCyc - evCyc[i] : evCyc[i+1] - evCyc[i];
      if (i == mrsIdx) chk(gap == TMRD, "R11 mode wait", gap, TMRD);
      else             chk(gap == TRC, "R4 refresh wait", gap, TRC);
    end
    chk(evAddr[mrsIdx] == expWord && !evFn[mrsIdx], "R7 mode word", evAddr[mrsIdx], expWord);
    chk(ready && !dqm && !cfgError, "R11 ready after init", {ready, dqm, cfgError}, 3'b100);
  endtask

  task automatic checkBad(input logic [9:0] v);
    string tag;
    int expEv;
    if (v[2:0] inside {3'b100, 3'b101, 3'b110}) tag = "R8";
    else if (v[2:0] == 3'b111) tag = "R9";
    else tag = "R10";
    expEv = v[8] ? 1 : NREF + 1;
    chk(cfgError && !ready, {tag, " error raised"}, {cfgError, ready}, 2'b10);
    chk(nEv == expEv, {tag, " no mode programming"}, nEv, expEv);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(cfgError && !ready && cmd == 4'b0111, {tag, " stays quiet"},
        {cfgError, ready, cmd}, 6'b10_0111);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NVEC; k++) begin
      runInit(VEC[k]);
      if (VEC[k][9]) checkGood(VEC[k]);
      else           checkBad(VEC[k]);
    end

    // special programming after a clean init
    runInit(VEC[0]);
    checkGood(VEC[0]);
    for (int m = 0; m < 2; m++) begin
      int n;
      specLoadMask  = (m == 0);
      specLoadColor = (m == 1);
      specReq = 1'b1;
      @(posedge clk);
      @(negedge clk);
      specReq = 1'b0;
      chk(cmd == 4'b0000 && fnSel && addr[5] == (m == 0) && addr[6] == (m == 1) && !ready,
          "R12 special command", {cmd, fnSel, addr[6:5], ready},
          {4'b0000, 1'b1, (m == 1), (m == 0), 1'b0});
      n = 0;
      for (int c = 0; c < 20; c++) begin
        @(posedge clk);
        @(negedge clk);
        n++;
        if (ready) break;
      end
      chk(n == TMRD, "R12 ready returns", n, TMRD);
    end

    specLoadMask = 1'b1;
    specLoadColor = 1'b1;
    specReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    specReq = 1'b0;
    chk(specReject && ready && cmd == 4'b0111 && !fnSel, "R13 both bits refused",
        {specReject, ready, cmd, fnSel}, 7'b11_0111_0);
    @(posedge clk);
    @(negedge clk);
    chk(!specReject && ready && cmd == 4'b0111, "R13 reject is one cycle",
        {specReject, ready, cmd}, 6'b01_0111);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule